// File: doc/BRIEF.md
# Power Switch Ramp Sequencer

This block brings up the power switch chain of a memory or logic domain in a fixed order. Once its enable bit is set, it raises a power-on request toward the switch chain. It then reports power-good to the domain. In slow mode, power-good follows after a programmed number of cycles, while a weak chain limits the inrush current. In fast mode, the weak chain is skipped and power-good follows at once. One cycle after power-good, a ready status rises. The analog switches are not modelled; every handshake is a digital signal.

The same configuration word also holds a precharge count for retention. When a retention request rises, the block drives a precharge pulse that lasts exactly that many cycles. The configuration word is written through a plain write port and read back in full. Reserved bits always read as zero.

Top module: `pwr_ramp_seq`

## Requirements
- R1: After reset the readback word is 0x0030_0017 (delay 0x30, precharge 0x17, enable and mode clear), and the power-on, power-good, ready and precharge outputs are all low.
- R2: Only bits 25, 24, 23:16 and 7:0 are stored. Writing 0xFFFF_FFFF reads back as 0x03FF_00FF, so bits 31:26 and 15:8 always read zero.
- R3: While the enable bit (bit 24) is clear, no sequence starts and power-on, power-good and ready stay low. Once the enable bit is stored, power-on rises on the next clock edge.
- R4: In slow mode (bit 25 = 0), power-good rises exactly 8 × D cycles after power-on rises, where D is bits 23:16 and D is at least 1. Power-good is never high while power-on is low.
- R5: Ready rises exactly one cycle after power-good rises, and stays high while the sequence is enabled.
- R6: In fast mode (bit 25 = 1), power-on and power-good rise in the same cycle.
- R7: In slow mode with D = 0, power-good rises one cycle after power-on, so the ramp does not hang.
- R8: Once a cleared enable bit is stored, power-on, power-good and ready are all low after the next clock edge, whatever state the sequence was in.
- R9: A rising edge on the retention request produces a precharge pulse lasting exactly P cycles, where P is bits 7:0. With P = 0 there is no pulse.
- R10: A new rising edge on the retention request while a pulse is running has no effect. The pulse neither restarts nor gets longer.
- R11: If a configuration write and a retention request rise on the same clock edge, the pulse uses the precharge count stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback, reserved bits zero |
| ret_req | input | 1 | Retention request; a rising edge starts precharge |
| pwr_on | output | 1 | Power-on request to the switch chain |
| pgood | output | 1 | Power-good indication to the domain |
| ready | output | 1 | Domain powered and ready |
| precharge | output | 1 | Precharge pulse for retention |

## Verification
A configuration write and the start of a precharge pulse can land on the same clock edge. Both then read the precharge field at that edge. The bench provokes this by driving the write strobe and the rising retention request in the same cycle, with different old and new counts. It judges the outcome by counting the pulse length: this pulse must match the old count, and the next request must match the new count. Sequencing and precharge are also run at the same time, and the ramp timing is checked while the write port is busy.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int CFG_W    = 32;
  localparam int MODE_POS = 25;
  localparam int EN_POS   = 24;
  localparam int DLY_LSB  = 16;
  localparam int PCH_LSB  = 0;

  typedef enum logic [1:0] {
    PS_OFF    = 2'd0,
    PS_WEAK   = 2'd1,
    PS_STRONG = 2'd2,
    PS_READY  = 2'd3
  } pwr_state_e;

endpackage

// File: rtl/pwr_cfg_reg.sv
module pwr_cfg_reg
  import pwr_seq_pkg::*;
#(
  parameter int          DLY_W   = 8,
  parameter int          PCH_W   = 8,
  parameter logic [7:0]  DLY_RST = 8'h30,
  parameter logic [7:0]  PCH_RST = 8'h17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output logic             en,
  output logic             fast,
  output logic [DLY_W-1:0] dly,
  output logic [PCH_W-1:0] pch
);

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= 1'b0;
      fast <= 1'b0;
      dly  <= DLY_W'(DLY_RST);
      pch  <= PCH_W'(PCH_RST);
    end else if (we) begin
      en   <= wdata[EN_POS];
      fast <= wdata[MODE_POS];
      dly  <= wdata[DLY_LSB +: DLY_W];
      pch  <= wdata[PCH_LSB +: PCH_W];
    end
  end

  always_comb begin
    rdata                    = '0;
    rdata[MODE_POS]          = fast;
    rdata[EN_POS]            = en;
    rdata[DLY_LSB +: DLY_W]  = dly;
    rdata[PCH_LSB +: PCH_W]  = pch;
  end

endmodule

// File: rtl/pwr_ramp_fsm.sv
module pwr_ramp_fsm
  import pwr_seq_pkg::*;
#(
  parameter int DLY_W = 8,
  parameter int MUL_SH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             fast,
  input  logic [DLY_W-1:0] dly,
  output logic             pwr_on,
  output logic             pgood,
  output logic             ready
);

  localparam int CNT_W = DLY_W + MUL_SH;

  pwr_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = PS_OFF;
    end else begin
      case (state_q)
        PS_OFF:    state_d = fast ? PS_STRONG : PS_WEAK;
        PS_WEAK:   if (cnt_q <= CNT_W'(1)) state_d = PS_STRONG;
        PS_STRONG: state_d = PS_READY;
        PS_READY:  state_d = PS_READY;
        default:   state_d = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_OFF;
      cnt_q   <= '0;
      pwr_on  <= 1'b0;
      pgood   <= 1'b0;
      ready   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == PS_OFF && en && !fast)
        cnt_q <= {dly, {MUL_SH{1'b0}}};
      else if (state_q == PS_WEAK && cnt_q != '0)
        cnt_q <= cnt_q - CNT_W'(1);
      pwr_on <= (state_d != PS_OFF);
      pgood  <= (state_d == PS_STRONG) || (state_d == PS_READY);
      ready  <= (state_d == PS_READY);
    end
  end

  a_r4_pgood_needs_pwr_on: assert property (@(posedge clk) disable iff (rst)
    pgood |-> pwr_on);
  a_r5_ready_after_pgood: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(pgood));
  a_r6_fast_same_cycle: assert property (@(posedge clk) disable iff (rst)
    ($rose(pwr_on) && $past(fast)) |-> pgood);
  a_r4_slow_waits: assert property (@(posedge clk) disable iff (rst)
    ($rose(pwr_on) && !$past(fast)) |-> !pgood);
  a_r8_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pwr_on && !pgood && !ready));

endmodule

// File: rtl/pwr_precharge.sv
module pwr_precharge #(
  parameter int PCH_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [PCH_W-1:0] pch,
  output logic             pulse
);

  logic             req_q;
  logic [PCH_W-1:0] left_q;
  logic             start;

  assign start = req && !req_q && (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      left_q <= '0;
    end else begin
      req_q <= req;
      if (start)
        left_q <= pch;
      else if (left_q != '0)
        left_q <= left_q - PCH_W'(1);
    end
  end

  assign pulse = (left_q != '0);

  a_r10_no_retrigger: assert property (@(posedge clk) disable iff (rst)
    (left_q > PCH_W'(1)) |=> (left_q == $past(left_q) - PCH_W'(1)));
  a_r9_zero_count_silent: assert property (@(posedge clk) disable iff (rst)
    (req && !req_q && !pulse && pch == '0) |=> !pulse);

endmodule

// File: rtl/pwr_ramp_seq.sv
module pwr_ramp_seq
  import pwr_seq_pkg::*;
#(
  parameter int         DLY_W   = 8,
  parameter int         PCH_W   = 8,
  parameter int         MUL_SH  = 3,
  parameter logic [7:0] DLY_RST = 8'h30,
  parameter logic [7:0] PCH_RST = 8'h17
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        ret_req,
  output logic        pwr_on,
  output logic        pgood,
  output logic        ready,
  output logic        precharge
);

  logic             en, fast;
  logic [DLY_W-1:0] dly;
  logic [PCH_W-1:0] pch;

  pwr_cfg_reg #(
    .DLY_W(DLY_W), .PCH_W(PCH_W), .DLY_RST(DLY_RST), .PCH_RST(PCH_RST)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .en(en), .fast(fast), .dly(dly), .pch(pch)
  );

  pwr_ramp_fsm #(.DLY_W(DLY_W), .MUL_SH(MUL_SH)) u_fsm (
    .clk(clk), .rst(rst), .en(en), .fast(fast), .dly(dly),
    .pwr_on(pwr_on), .pgood(pgood), .ready(ready)
  );

  pwr_precharge #(.PCH_W(PCH_W)) u_pch (
    .clk(clk), .rst(rst), .req(ret_req), .pch(pch), .pulse(precharge)
  );

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[31:26] == 6'd0) && (cfg_rdata[15:8] == 8'd0));
  a_r3_idle_when_off: assert property (@(posedge clk) disable iff (rst)
    (!en && !pwr_on) |=> !pwr_on);

endmodule

// File: tb/pwr_ramp_seq_test.sv
`timescale 1ns/1ps
module pwr_ramp_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        ret_req = 1'b0;
  logic        pwr_on, pgood, ready, precharge;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  pwr_ramp_seq uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ret_req(ret_req), .pwr_on(pwr_on),
    .pgood(pgood), .ready(ready), .precharge(precharge)
  );

  // columns: delay field, mode bit, expected cycles power-on -> power-good
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{1, 0, 8}, '{3, 0, 24}, '{0, 0, 1}, '{5, 1, 0}, '{48, 0, 384}, '{2, 1, 0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] mk(input bit fast, input bit en, input int d, input int p);
    return {6'd0, fast, en, d[7:0], 8'd0, p[7:0]};
  endfunction

  task automatic count_pulse(output int n);
    n = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (precharge) n++;
    end
  endtask

  initial begin
    #(200000 * 5);
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, -1);
    errs++;
    checks++;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int n, k;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(cfg_rdata == 32'h0030_0017, "R1 readback", cfg_rdata, 32'h0030_0017);
    chk({pwr_on, pgood, ready, precharge} == 4'b0, "R1 outputs", {pwr_on, pgood, ready, precharge}, 0);

    // R2 reserved bits
    wr(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h03FF_00FF, "R2 reserved zero", cfg_rdata, 32'h03FF_00FF);
    wr(32'h0);
    @(negedge clk);
    chk({pwr_on, pgood, ready} == 3'b0, "R8 off after clear", {pwr_on, pgood, ready}, 0);

    // R3 disabled: nothing starts, even with fields set
    wr(mk(1'b1, 1'b0, 4, 3));
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwr_on || pgood || ready) n++;
    end
    chk(n == 0, "R3 no sequence while disabled", n, 0);

    // table of ramp vectors: R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      wr(mk(VEC[v][1] != 0, 1'b1, VEC[v][0], 0));
      n = 0;
      while (!pwr_on && n < 10) begin
        @(negedge clk);
        n++;
      end
      chk(n == 1, "R3 power-on one edge after enable", n, 1);
      k = 0;
      while (!pgood && k < 3000) begin
        @(negedge clk);
        k++;
        chk(pwr_on, "R4 power-on held during ramp", pwr_on, 1);
      end
      if (VEC[v][1] != 0)
        chk(k == VEC[v][2], "R6 fast ramp", k, VEC[v][2]);
      else if (VEC[v][0] == 0)
        chk(k == VEC[v][2], "R7 zero delay", k, VEC[v][2]);
      else
        chk(k == VEC[v][2], "R4 slow ramp delay", k, VEC[v][2]);
      chk(!ready, "R5 ready not with power-good", ready, 0);
      @(negedge clk);
      chk(ready && pgood && pwr_on, "R5 ready next cycle", ready, 1);
      wr(32'h0);
      @(negedge clk);
      chk({pwr_on, pgood, ready} == 3'b0, "R8 off after clear", {pwr_on, pgood, ready}, 0);
    end

    // R8 clear during the weak ramp
    wr(mk(1'b0, 1'b1, 10, 0));
    repeat (5) @(negedge clk);
    chk(pwr_on && !pgood, "R4 mid ramp", pwr_on, 1);
    wr(32'h0);
    @(negedge clk);
    chk({pwr_on, pgood, ready} == 3'b0, "R8 clear mid ramp", {pwr_on, pgood, ready}, 0);

    // R9 precharge length
    wr(mk(1'b0, 1'b0, 0, 4));
    @(negedge clk); ret_req = 1'b1;
    count_pulse(n);
    chk(n == 4, "R9 pulse length", n, 4);
    ret_req = 1'b0;
    wr(mk(1'b0, 1'b0, 0, 0));
    @(negedge clk); ret_req = 1'b1;
    count_pulse(n);
    chk(n == 0, "R9 zero count no pulse", n, 0);
    ret_req = 1'b0;

    // R10 retrigger ignored
    wr(mk(1'b0, 1'b0, 0, 12));
    @(negedge clk); ret_req = 1'b1;
    n = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (precharge) n++;
    end
    ret_req = 1'b0;
    @(negedge clk);
    if (precharge) n++;
    ret_req = 1'b1;
    count_pulse(k);
    chk(n + k == 12, "R10 retrigger ignored", n + k, 12);
    ret_req = 1'b0;

    // R11 write and request on the same edge, while sequence runs fast
    wr(mk(1'b1, 1'b1, 0, 9));
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = mk(1'b1, 1'b1, 0, 5);
    ret_req = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    n = precharge ? 1 : 0;
    for (int i = 0; i < 299; i++) begin
      @(negedge clk);
      if (precharge) n++;
    end
    chk(n == 9, "R11 old count used", n, 9);
    chk(ready && pgood, "R5 sequence undisturbed", ready, 1);
    ret_req = 1'b0;
    @(negedge clk); ret_req = 1'b1;
    count_pulse(n);
    chk(n == 5, "R11 new count next time", n, 5);
    ret_req = 1'b0;

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule